// File: doc/BRIEF.md
# Serial ADC Command-and-Capture Master

This block runs a single conversion on an external 10-bit, 8-channel serial converter over a four-wire link made of a chip select, a serial clock, a command line out and a data line in. A request carries a mode flag (single-ended or differential) and a channel number. The block pulls chip select low and derives the serial clock from the system clock. It sends a start bit, the mode bit and the channel bits. It then reads the converter's null bit and the ten result bits. The result comes back with a one-cycle done pulse.

With the check option set on a request, the frame keeps running after the last result bit. The converter then sends the result again, least significant bit first. The block gathers this repeat, reverses it and compares it with the first copy. A mismatch flag reports any disagreement, and also reports a null bit that was not zero. After each frame the block holds chip select high for a set minimum number of system clocks before it accepts another request.

Top module: `adc_frame_master`

## Requirements
- R1: After reset, chip select is high, the serial clock and command line are low, `res_valid` is low and `req_ready` is high. A request is taken in a cycle where both `req_valid` and `req_ready` are high, and chip select is low in the next cycle.
- R2: The serial clock is low whenever chip select is high. Inside a frame each clock level lasts `DIV_HALF` system clocks, so a frame of N rising edges keeps chip select low for 2·N·`DIV_HALF` system clocks.
- R3: The command line carries 1, then `req_single`, then `req_chan[2]`, `req_chan[1]` and `req_chan[0]`. These are sampled on rising edges 1 to 5 and are changed only while the clock is low. The line is 0 for every later edge and whenever chip select is high.
- R4: The data line is sampled on rising edges. Edge 7 carries the null bit, and edges 8 to 17 carry result bits 9 down to 0, which appear on `res_data`.
- R5: Without the check option a frame has exactly 17 rising edges. Chip select rises at the next falling point of the clock, in the same cycle as a one-cycle `res_valid` pulse.
- R6: With the check option a frame has exactly 26 rising edges. Edges 18 to 26 carry result bits 1 up to 9 of the repeat.
- R7: `res_mismatch` is 1 when the null bit was 1, in either mode. With the check option it is also 1 when the repeat disagrees with bits 9..1 of the first copy. Without the check option the repeat is never read and cannot set the flag.
- R8: Between two frames chip select stays high for at least `CS_GAP` system clocks.
- R9: `res_data` and `res_mismatch` change only in a cycle where `res_valid` is high.
- R10: A request raised while `req_ready` is low is dropped and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start strobe |
| req_single | input | 1 | Mode bit sent after the start bit (1 = single-ended) |
| req_chan | input | CH_W | Channel number, most significant bit sent first |
| req_check | input | 1 | Extend the frame and cross-check the repeat |
| req_ready | output | 1 | Block is idle and the chip-select gap has elapsed |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_sclk | output | 1 | Serial clock, idles low |
| adc_mosi | output | 1 | Command line to the converter |
| adc_miso | input | 1 | Data line from the converter |
| res_valid | output | 1 | One-cycle pulse when a frame is complete |
| res_data | output | RES_W | Result, held until the next pulse |
| res_mismatch | output | 1 | Null-bit or repeat-check error for the held result |

## Verification
The bench sweeps every combination of mode bit, channel number and check option. Each combination gets a different result value, so a swapped or misplaced command bit shows up as a wrong command pattern, and a misplaced capture edge shows up as a wrong result. All-zero, all-one and alternating results separate stuck-at faults and off-by-one faults in the shift path. A frame with a null bit of 1 in each mode, and a corrupted repeat in each mode, tell apart the null check, the repeat check, and the rule that the repeat is ignored in the basic frame. Edge counts, chip-select low time and high time, and a request made during the gap check the frame length and the acceptance rules.

// File: rtl/adcm_pkg.sv
package adcm_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } adcm_state_e;
endpackage

// File: rtl/adcm_sclk_gen.sv
module adcm_sclk_gen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [DW-1:0] CNT_TOP = DW'(DIV_HALF - 1);

    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || cnt_q == CNT_TOP) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = run && (cnt_q == CNT_TOP);
endmodule

// File: rtl/adcm_gap_timer.sv
module adcm_gap_timer #(
    parameter int CS_GAP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic open
);
    localparam int GW = $clog2(CS_GAP + 1);
    localparam logic [GW-1:0] GAP_LOAD = GW'(CS_GAP);

    logic [GW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = GAP_LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign open = (cnt_q == '0);
endmodule

// File: rtl/adcm_capture.sv
module adcm_capture #(
    parameter int RES_W     = 10,
    parameter int EDGE_W    = 5,
    parameter int NULL_EDGE = 7,
    parameter int LAST_DATA = 17,
    parameter int LAST_REP  = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              smp,
    input  logic [EDGE_W-1:0] edge_no,
    input  logic              miso,
    output logic              null_bit,
    output logic [RES_W-1:0]  word,
    output logic [RES_W-2:0]  rep
);
    localparam logic [EDGE_W-1:0] E_NULL  = EDGE_W'(NULL_EDGE);
    localparam logic [EDGE_W-1:0] E_DLAST = EDGE_W'(LAST_DATA);
    localparam logic [EDGE_W-1:0] E_RLAST = EDGE_W'(LAST_REP);

    typedef struct packed {
        logic             nbit;
        logic [RES_W-1:0] word;
        logic [RES_W-2:0] rep;
    } cap_s;

    cap_s cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (clr) begin
            cap_d = '0;
        end else if (smp) begin
            if (edge_no == E_NULL) begin
                cap_d.nbit = miso;
            end else if (edge_no > E_NULL && edge_no <= E_DLAST) begin
                cap_d.word = {cap_q.word[RES_W-2:0], miso};
            end else if (edge_no > E_DLAST && edge_no <= E_RLAST) begin
                cap_d.rep = {miso, cap_q.rep[RES_W-2:1]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign null_bit = cap_q.nbit;
    assign word     = cap_q.word;
    assign rep      = cap_q.rep;
endmodule

// File: rtl/adc_frame_master.sv
module adc_frame_master
    import adcm_pkg::*;
#(
    parameter int DIV_HALF = 2,
    parameter int CS_GAP   = 4,
    parameter int RES_W    = 10,
    parameter int CH_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_single,
    input  logic [CH_W-1:0]  req_chan,
    input  logic             req_check,
    output logic             req_ready,
    output logic             adc_cs_n,
    output logic             adc_sclk,
    output logic             adc_mosi,
    input  logic             adc_miso,
    output logic             res_valid,
    output logic [RES_W-1:0] res_data,
    output logic             res_mismatch
);
    localparam int CMD_BITS  = 2 + CH_W;
    localparam int NULL_EDGE = CMD_BITS + 2;
    localparam int LAST_DATA = NULL_EDGE + RES_W;
    localparam int LAST_REP  = LAST_DATA + RES_W - 1;
    localparam int EDGE_W    = $clog2(LAST_REP + 1);
    localparam logic [EDGE_W-1:0] E_BASIC = EDGE_W'(LAST_DATA);
    localparam logic [EDGE_W-1:0] E_CHECK = EDGE_W'(LAST_REP);

    typedef struct packed {
        adcm_state_e      st;
        logic             cs_n;
        logic             sclk;
        logic             mosi;
        logic [CH_W:0]    cmd_sh;
        logic [EDGE_W-1:0] edge_no;
        logic             chk;
        logic             valid;
        logic [RES_W-1:0] data;
        logic             mism;
    } top_s;

    top_s q, d;

    logic             tick;
    logic             gap_open;
    logic             accept;
    logic             rise_tick;
    logic             done_now;
    logic [EDGE_W-1:0] edge_next;
    logic [EDGE_W-1:0] edge_last;
    logic             cap_null;
    logic [RES_W-1:0] cap_word;
    logic [RES_W-2:0] cap_rep;

    adcm_sclk_gen #(.DIV_HALF(DIV_HALF)) u_sclk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.st == ST_XFER),
        .tick  (tick)
    );

    adcm_gap_timer #(.CS_GAP(CS_GAP)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (done_now),
        .open  (gap_open)
    );

    adcm_capture #(
        .RES_W     (RES_W),
        .EDGE_W    (EDGE_W),
        .NULL_EDGE (NULL_EDGE),
        .LAST_DATA (LAST_DATA),
        .LAST_REP  (LAST_REP)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .smp      (rise_tick),
        .edge_no  (edge_next),
        .miso     (adc_miso),
        .null_bit (cap_null),
        .word     (cap_word),
        .rep      (cap_rep)
    );

    assign req_ready = (q.st == ST_IDLE) && gap_open;
    assign accept    = req_valid && req_ready;
    assign rise_tick = (q.st == ST_XFER) && tick && !q.sclk;
    assign edge_next = q.edge_no + 1'b1;
    assign edge_last = q.chk ? E_CHECK : E_BASIC;
    assign done_now  = (q.st == ST_XFER) && tick && q.sclk && (q.edge_no == edge_last);

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    d.st      = ST_XFER;
                    d.cs_n    = 1'b0;
                    d.sclk    = 1'b0;
                    d.mosi    = 1'b1;
                    d.cmd_sh  = {req_single, req_chan};
                    d.edge_no = '0;
                    d.chk     = req_check;
                end
            end
            ST_XFER: begin
                if (tick) begin
                    if (!q.sclk) begin
                        d.sclk    = 1'b1;
                        d.edge_no = edge_next;
                    end else begin
                        d.sclk = 1'b0;
                        if (done_now) begin
                            d.st    = ST_IDLE;
                            d.cs_n  = 1'b1;
                            d.mosi  = 1'b0;
                            d.valid = 1'b1;
                            d.data  = cap_word;
                            d.mism  = cap_null ||
                                      (q.chk && (cap_rep != cap_word[RES_W-1:1]));
                        end else begin
                            d.mosi   = q.cmd_sh[CH_W];
                            d.cmd_sh = {q.cmd_sh[CH_W-1:0], 1'b0};
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.cs_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign adc_cs_n     = q.cs_n;
    assign adc_sclk     = q.sclk;
    assign adc_mosi     = q.mosi;
    assign res_valid    = q.valid;
    assign res_data     = q.data;
    assign res_mismatch = q.mism;
endmodule

// File: rtl/adcm_checker.sv
module adcm_checker #(
    parameter int CS_GAP = 4,
    parameter int RES_W  = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             adc_cs_n,
    input logic             adc_sclk,
    input logic             adc_mosi,
    input logic             res_valid,
    input logic [RES_W-1:0] res_data,
    input logic             res_mismatch
);
    localparam int HW = $clog2(CS_GAP + 2);
    localparam logic [HW-1:0] HI_MAX = {HW{1'b1}};

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= HI_MAX;
        end else if (!adc_cs_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt != HI_MAX) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> adc_cs_n);

    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !adc_cs_n);

    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> !adc_sclk);

    p_mosi_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> !adc_mosi);

    p_mosi_low_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_sclk && !adc_cs_n) |-> $stable(adc_mosi));

    p_cs_rise_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cs_n) |-> res_valid);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> (hi_cnt >= HW'(CS_GAP)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(res_data) && $stable(res_mismatch)));
endmodule

bind adc_frame_master adcm_checker #(.CS_GAP(CS_GAP), .RES_W(RES_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .adc_cs_n     (adc_cs_n),
    .adc_sclk     (adc_sclk),
    .adc_mosi     (adc_mosi),
    .res_valid    (res_valid),
    .res_data     (res_data),
    .res_mismatch (res_mismatch)
);

// File: tb/tb_adc_frame_master.sv
`timescale 1ns/1ps
module tb_adc_frame_master;
    localparam int DIV_HALF = 2;
    localparam int CS_GAP   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_single = 1'b0;
    logic [2:0] req_chan = 3'd0;
    logic       req_check = 1'b0;
    logic       req_ready;
    logic       adc_cs_n, adc_sclk, adc_mosi, adc_miso;
    logic       res_valid;
    logic [9:0] res_data;
    logic       res_mismatch;

    int n_chk = 0;
    int n_err = 0;

    int rises = 0;
    int falls = 0;
    logic [31:0] mosi_hist = '0;
    int falls_base = 0;
    int rises_base = 0;
    int low_cnt = 0;
    int hi_run = 1000;
    int last_hi = 1000;
    logic [9:0] m_val = '0;
    logic m_bad_null = 1'b0;
    logic m_bad_rep = 1'b0;

    always #2.5 clk = ~clk;

    adc_frame_master #(.DIV_HALF(DIV_HALF), .CS_GAP(CS_GAP)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_single(req_single),
        .req_chan(req_chan), .req_check(req_check), .req_ready(req_ready),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_mosi(adc_mosi),
        .adc_miso(adc_miso), .res_valid(res_valid), .res_data(res_data),
        .res_mismatch(res_mismatch)
    );

    // converter model: bit presented for the upcoming rising edge e
    function automatic logic conv_bit(int e, logic [9:0] v, logic bn, logic br);
        if (e <= 6) return 1'b1;
        if (e == 7) return bn;
        if (e <= 17) return v[17 - e];
        if (e <= 26) return v[e - 17] ^ (br && e == 20);
        return 1'b0;
    endfunction

    assign adc_miso = conv_bit(falls - falls_base + 1, m_val, m_bad_null, m_bad_rep);

    always @(posedge adc_sclk) begin
        rises <= rises + 1;
        mosi_hist <= {mosi_hist[30:0], adc_mosi};
    end

    always @(negedge adc_sclk) falls <= falls + 1;

    always @(negedge clk) begin
        if (!adc_cs_n) begin
            low_cnt <= low_cnt + 1;
            if (hi_run != 0) begin
                last_hi <= hi_run;
                hi_run <= 0;
            end
        end else begin
            hi_run <= hi_run + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic frame(input logic single, input logic [2:0] chan, input logic chk,
                         input logic [9:0] val, input logic bn, input logic br);
        int n;
        int cmd;
        int tail;
        logic exp_m;
        n = chk ? 26 : 17;
        exp_m = bn | (chk & br);
        while (!req_ready) @(negedge clk);
        m_val = val;
        m_bad_null = bn;
        m_bad_rep = br;
        falls_base = falls;
        rises_base = rises;
        low_cnt = 0;
        req_single = single;
        req_chan = chan;
        req_check = chk;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(adc_cs_n == 1'b0, "R1 cs low after accept", int'(adc_cs_n), 0);
        check(last_hi >= CS_GAP, "R8 cs high gap", last_hi, CS_GAP);
        while (!res_valid) @(negedge clk);
        check(res_data == val, "R4 result", int'(res_data), int'(val));
        check(res_mismatch == exp_m, "R7 mismatch", int'(res_mismatch), int'(exp_m));
        check(adc_cs_n == 1'b1, "R5 cs rises with done", int'(adc_cs_n), 1);
        check(rises - rises_base == n, chk ? "R6 edge count" : "R5 edge count",
              rises - rises_base, n);
        cmd = int'((mosi_hist >> (n - 5)) & 32'h1f);
        check(cmd == int'({1'b1, single, chan}), "R3 command bits", cmd,
              int'({1'b1, single, chan}));
        tail = int'(mosi_hist & ((32'h1 << (n - 5)) - 1));
        check(tail == 0, "R3 line quiet after command", tail, 0);
        check(low_cnt == 2 * n * DIV_HALF, "R2 frame length", low_cnt, 2 * n * DIV_HALF);
        // request while not ready must be dropped
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R10 not ready in gap", int'(req_ready), 0);
        @(negedge clk);
        check(adc_cs_n == 1'b1, "R10 stray request ignored", int'(adc_cs_n), 1);
        check(res_data == val, "R9 result held", int'(res_data), int'(val));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R5 actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(adc_cs_n == 1'b1, "R1 reset cs", int'(adc_cs_n), 1);
        check(adc_sclk == 1'b0, "R2 reset sclk", int'(adc_sclk), 0);
        check(adc_mosi == 1'b0, "R3 reset mosi", int'(adc_mosi), 0);
        check(res_valid == 1'b0, "R1 reset valid", int'(res_valid), 0);
        check(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
        for (int c = 0; c < 2; c++) begin
            for (int s = 0; s < 2; s++) begin
                for (int ch = 0; ch < 8; ch++) begin
                    frame(s[0], ch[2:0], c[0], 10'((ch * 97 + s * 311 + c * 45 + 3) % 1024),
                          1'b0, 1'b0);
                end
            end
        end
        frame(1'b1, 3'd0, 1'b1, 10'h000, 1'b0, 1'b0);
        frame(1'b1, 3'd7, 1'b1, 10'h3ff, 1'b0, 1'b0);
        frame(1'b0, 3'd5, 1'b1, 10'h2aa, 1'b0, 1'b0);
        frame(1'b0, 3'd2, 1'b0, 10'h155, 1'b0, 1'b0);
        frame(1'b1, 3'd3, 1'b0, 10'h1c3, 1'b1, 1'b0); // R7 null error, basic
        frame(1'b1, 3'd4, 1'b1, 10'h0f0, 1'b1, 1'b0); // R7 null error, checked
        frame(1'b0, 3'd6, 1'b1, 10'h2d7, 1'b0, 1'b1); // R7 repeat error, checked
        frame(1'b0, 3'd1, 1'b0, 10'h2d7, 1'b0, 1'b1); // R7 repeat unread, basic
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule